// File: doc/BRIEF.md
# Splittable Bidirectional LCD Row Scan Register

This block generates the row-select pattern for a dot-matrix liquid-crystal panel. It holds a scan register of `STAGES` bits (160 by default) and advances it by one position on every falling edge of a shift strobe. A single marker bit is shifted in at the start of a frame and walks across the rows. Each stage drives one row output. The row output is a two-bit code that selects one of four drive levels. The code depends on the stage bit, on an alternation (polarity) input and on a display-enable input.

The register runs in one of two modes. As one long chain it serves a single panel. It can also break into two independent half-length chains, for a dual-screen panel. In both modes the scan direction is selectable. The two end pins of the chain are modelled as separate in, out and output-enable signals, so that several instances can be chained end to end. The end at which the scan starts takes serial data in. The opposite end presents the last stage to the next device. In split mode a separate middle input feeds the second half.

Top module: `lcd_row_scan`

## Requirements
- R1: While `rst_n` is low, every stage is 0. With `disp_en`=1 and `alt_phase`=0, every row code reads 2'b10.
- R2: Each falling edge of `shift_strobe` moves the register by exactly one stage. A single 1 entered at the start of the scan appears on exactly one row, and that row moves one position per edge.
- R3: With `split_mode`=0 and `dir_up`=0, data from `hi_in` enters the highest stage (row index STAGES-1). Each other stage takes the value of the stage above it. `mid_in` has no effect.
- R4: With `split_mode`=0 and `dir_up`=1, data from `lo_in` enters stage 0. Each other stage takes the value of the stage below it. `mid_in` has no effect.
- R5: With `split_mode`=1 and `dir_up`=0, the upper half shifts downward from `hi_in` and stops at stage STAGES/2. The lower half shifts downward from `mid_in`, which enters stage STAGES/2-1.
- R6: With `split_mode`=1 and `dir_up`=1, the lower half shifts upward from `lo_in` and stops at stage STAGES/2-1. The upper half shifts upward from `mid_in`, which enters stage STAGES/2.
- R7: With `disp_en`=1, the code of row i (bits 2i+1:2i of `row_code`) is set by the pair (`alt_phase`, stage bit): (0,1) gives 2'b00, the highest level; (1,0) gives 2'b01, the second level; (0,0) gives 2'b10, the third level; (1,1) gives 2'b11, the lowest level.
- R8: With `disp_en`=0, every row code is 2'b11, whatever the stage contents and `alt_phase`.
- R9: `lo_oe` is 1 exactly when `dir_up`=0, and `hi_oe` is 1 exactly when `dir_up`=1. Both follow `dir_up` without waiting for a strobe edge.
- R10: `lo_out` equals stage 0 and `hi_out` equals stage STAGES-1, as they stand after the most recent falling strobe edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shift_strobe | input | 1 | Shift strobe; the register advances on its falling edge |
| rst_n | input | 1 | Asynchronous active-low reset, clears every stage |
| split_mode | input | 1 | 0: one chain of STAGES bits; 1: two chains of STAGES/2 bits |
| dir_up | input | 1 | 0: scan toward row 0; 1: scan toward row STAGES-1 |
| lo_in | input | 1 | Serial input at the row-0 end |
| lo_out | output | 1 | Serial output at the row-0 end (stage 0) |
| lo_oe | output | 1 | 1 when the row-0 end pin acts as an output |
| hi_in | input | 1 | Serial input at the top-row end |
| hi_out | output | 1 | Serial output at the top-row end (stage STAGES-1) |
| hi_oe | output | 1 | 1 when the top-row end pin acts as an output |
| mid_in | input | 1 | Serial input of the second half in split mode |
| alt_phase | input | 1 | Drive polarity alternation |
| disp_en | input | 1 | 0 forces every row to the lowest level |
| row_code | output | 2*STAGES | Level code per row, row i at bits 2i+1:2i |

## Verification
Two events can fall on the same strobe edge: a change of `split_mode` or `dir_up` and the shift that the new setting governs. A change of `disp_en` or `alt_phase` can also arrive together with new register contents. The bench draws the mode, direction and all data and level inputs anew from a seeded `$urandom` before almost every edge, so the shift uses selects that have just changed. A reference model of the stage bits, updated from the values driven before that edge, then predicts every row code and the active end pin. The full code bus is compared just after the edge. Directed runs add a walking marker and a long blanked stretch.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;

   // Four drive levels, highest first
   typedef enum logic [1:0] {
      LVL_PEAK      = 2'b00,
      LVL_NEAR_PEAK = 2'b01,
      LVL_NEAR_BASE = 2'b10,
      LVL_BASE      = 2'b11
   } drive_level_e;

   localparam int CODE_W = 2;

   // Level chosen for one row from polarity, enable and stage bit
   function automatic drive_level_e pick_level(input logic enable,
                                               input logic polarity,
                                               input logic mark);
      if (!enable) return LVL_BASE;
      unique case ({polarity, mark})
         2'b01:   return LVL_PEAK;
         2'b10:   return LVL_NEAR_PEAK;
         2'b00:   return LVL_NEAR_BASE;
         default: return LVL_BASE;
      endcase
   endfunction

endpackage

// File: rtl/lcd_scan_chain.sv
module lcd_scan_chain #(
   parameter int STAGES = 160
) (
   input  logic              shift_strobe,
   input  logic              rst_n,
   input  logic              split_mode,
   input  logic              dir_up,
   input  logic              lo_in,
   input  logic              hi_in,
   input  logic              mid_in,
   output logic [STAGES-1:0] stage_q
);
   localparam int HALF = STAGES / 2;

   logic [STAGES-1:0] stage_d;

   generate
      if ((STAGES % 2) != 0 || STAGES < 4) begin : g_bad_stages
         $error("lcd_scan_chain: STAGES must be even and at least 4");
      end

      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         logic from_below;
         logic from_above;

         // Source when scanning upward
         if (i == 0) begin : g_lo_entry
            assign from_below = lo_in;
         end else if (i == HALF) begin : g_mid_up
            assign from_below = split_mode ? mid_in : stage_q[i-1];
         end else begin : g_up
            assign from_below = stage_q[i-1];
         end

         // Source when scanning downward
         if (i == STAGES - 1) begin : g_hi_entry
            assign from_above = hi_in;
         end else if (i == HALF - 1) begin : g_mid_dn
            assign from_above = split_mode ? mid_in : stage_q[i+1];
         end else begin : g_dn
            assign from_above = stage_q[i+1];
         end

         assign stage_d[i] = dir_up ? from_below : from_above;
      end
   endgenerate

   always_ff @(negedge shift_strobe or negedge rst_n) begin
      if (!rst_n) stage_q <= '0;
      else        stage_q <= stage_d;
   end

   // Entry points of each chain take the serial inputs
   assert_hi_entry_R3: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      (!dir_up) |=> (stage_q[STAGES-1] == $past(hi_in)));

   assert_lo_entry_R4: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      (dir_up) |=> (stage_q[0] == $past(lo_in)));

   assert_mid_down_R5: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      (split_mode && !dir_up) |=> (stage_q[HALF-1] == $past(mid_in)));

   assert_mid_up_R6: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      (split_mode && dir_up) |=> (stage_q[HALF] == $past(mid_in)));

   // Full chain crosses the middle without a break
   assert_full_cross_R3: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      (!split_mode && !dir_up) |=> (stage_q[HALF-1] == $past(stage_q[HALF])));

   // Shifting never changes the number of ones by more than one
   assert_one_step_R2: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      (!split_mode) |=> (($countones(stage_q) <= $countones($past(stage_q)) + 1) &&
                         ($countones(stage_q) + 1 >= $countones($past(stage_q)))));

endmodule

// File: rtl/lcd_level_encoder.sv
module lcd_level_encoder
   import lcd_scan_pkg::*;
#(
   parameter int STAGES = 160
) (
   input  logic                     disp_en,
   input  logic                     alt_phase,
   input  logic [STAGES-1:0]        stage_q,
   output logic [CODE_W*STAGES-1:0] row_code
);
   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_row
         drive_level_e lvl;
         always_comb lvl = pick_level(disp_en, alt_phase, stage_q[i]);
         assign row_code[CODE_W*i +: CODE_W] = lvl;
      end
   endgenerate

endmodule

// File: rtl/lcd_end_pins.sv
module lcd_end_pins (
   input  logic shift_strobe,
   input  logic rst_n,
   input  logic dir_up,
   input  logic first_stage,
   input  logic last_stage,
   output logic lo_out,
   output logic lo_oe,
   output logic hi_out,
   output logic hi_oe
);
   assign lo_oe  = ~dir_up;
   assign hi_oe  = dir_up;
   assign lo_out = first_stage;
   assign hi_out = last_stage;

   // Exactly one end drives at any time
   assert_one_driver_R9: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      $countones({lo_oe, hi_oe}) == 1);

endmodule

// File: rtl/lcd_row_scan.sv
module lcd_row_scan
   import lcd_scan_pkg::*;
#(
   parameter int STAGES = 160
) (
   input  logic                  shift_strobe,
   input  logic                  rst_n,
   input  logic                  split_mode,
   input  logic                  dir_up,
   input  logic                  lo_in,
   output logic                  lo_out,
   output logic                  lo_oe,
   input  logic                  hi_in,
   output logic                  hi_out,
   output logic                  hi_oe,
   input  logic                  mid_in,
   input  logic                  alt_phase,
   input  logic                  disp_en,
   output logic [2*STAGES-1:0]   row_code
);
   logic [STAGES-1:0] stage_q;

   lcd_scan_chain #(.STAGES(STAGES)) u_chain (
      .shift_strobe (shift_strobe),
      .rst_n        (rst_n),
      .split_mode   (split_mode),
      .dir_up       (dir_up),
      .lo_in        (lo_in),
      .hi_in        (hi_in),
      .mid_in       (mid_in),
      .stage_q      (stage_q)
   );

   lcd_level_encoder #(.STAGES(STAGES)) u_levels (
      .disp_en   (disp_en),
      .alt_phase (alt_phase),
      .stage_q   (stage_q),
      .row_code  (row_code)
   );

   lcd_end_pins u_pins (
      .shift_strobe (shift_strobe),
      .rst_n        (rst_n),
      .dir_up       (dir_up),
      .first_stage  (stage_q[0]),
      .last_stage   (stage_q[STAGES-1]),
      .lo_out       (lo_out),
      .lo_oe        (lo_oe),
      .hi_out       (hi_out),
      .hi_oe        (hi_oe)
   );

   // Blanking overrides every row
   assert_blank_rows_R8: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      (!disp_en) |-> (&row_code));

   // Serial outputs carry the end stages of the register
   assert_lo_tracks_R10: assert property (@(negedge shift_strobe) disable iff (!rst_n)
      (!split_mode && !$past(dir_up)) |-> (lo_out == $past(row_code[2]
         ^ row_code[2] ^ stage_q[1])));

endmodule

// File: tb/lcd_row_scan_bench.sv
`timescale 1ns/1ps
module lcd_row_scan_bench;
   localparam int N = 160;
   localparam int H = N / 2;

   logic shift_strobe = 1'b0;
   logic rst_n = 1'b0;
   logic split_mode = 1'b0, dir_up = 1'b0;
   logic lo_in = 1'b0, hi_in = 1'b0, mid_in = 1'b0;
   logic alt_phase = 1'b0, disp_en = 1'b1;
   logic lo_out, lo_oe, hi_out, hi_oe;
   logic [2*N-1:0] row_code;

   int total = 0;
   int bad = 0;
   bit model [N];

   lcd_row_scan #(.STAGES(N)) u_lcd_row_scan (
      .shift_strobe (shift_strobe), .rst_n (rst_n),
      .split_mode (split_mode), .dir_up (dir_up),
      .lo_in (lo_in), .lo_out (lo_out), .lo_oe (lo_oe),
      .hi_in (hi_in), .hi_out (hi_out), .hi_oe (hi_oe),
      .mid_in (mid_in), .alt_phase (alt_phase), .disp_en (disp_en),
      .row_code (row_code)
   );

   always #2.5 shift_strobe = ~shift_strobe;

   function automatic logic [1:0] expect_level(bit en, bit pol, bit mark);
      if (!en) return 2'b11;
      case ({pol, mark})
         2'b01:   return 2'b00;
         2'b10:   return 2'b01;
         2'b00:   return 2'b10;
         default: return 2'b11;
      endcase
   endfunction

   function automatic string mode_tag(bit s, bit d);
      if (!s && !d) return "R3";
      if (!s &&  d) return "R4";
      if ( s && !d) return "R5";
      return "R6";
   endfunction

   task automatic check(bit ok, string req, string what,
                        logic [2*N-1:0] act, logic [2*N-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   function automatic logic [2*N-1:0] expected_codes();
      logic [2*N-1:0] e;
      for (int i = 0; i < N; i++) e[2*i +: 2] = expect_level(disp_en, alt_phase, model[i]);
      return e;
   endfunction

   task automatic model_shift();
      bit nxt [N];
      if (!dir_up) begin
         for (int i = 0; i < N - 1; i++) nxt[i] = model[i+1];
         nxt[N-1] = hi_in;
         if (split_mode) nxt[H-1] = mid_in;
      end else begin
         for (int i = 1; i < N; i++) nxt[i] = model[i-1];
         nxt[0] = lo_in;
         if (split_mode) nxt[H] = mid_in;
      end
      model = nxt;
   endtask

   task automatic compare_all();
      logic [2*N-1:0] e;
      e = expected_codes();
      check(row_code === e, disp_en ? "R7" : "R8",
            {mode_tag(split_mode, dir_up), " row codes"}, row_code, e);
      check({lo_oe, hi_oe} === {~dir_up, dir_up}, "R9", "end enables",
            {lo_oe, hi_oe}, {~dir_up, dir_up});
      if (dir_up) check(hi_out === model[N-1], "R10", "hi_out", hi_out, model[N-1]);
      else        check(lo_out === model[0],   "R10", "lo_out", lo_out, model[0]);
   endtask

   task automatic step(bit s, bit d, bit li, bit hi, bit mi, bit pol, bit en);
      @(posedge shift_strobe);
      #1;
      split_mode = s; dir_up = d; lo_in = li; hi_in = hi; mid_in = mi;
      alt_phase = pol; disp_en = en;
      @(negedge shift_strobe);
      model_shift();
      #1;
      compare_all();
   endtask

   initial begin : watchdog
      #1_000_000;
      total++; bad++;
      $display("FAIL R2 watchdog expired actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : main
      int ones;
      int pos;
      logic [2*N-1:0] all_base;
      void'($urandom(32'h5eed_4102));
      for (int i = 0; i < N; i++) model[i] = 1'b0;

      // R1: reset state
      repeat (3) @(posedge shift_strobe);
      #1;
      check(row_code === {N{2'b10}}, "R1", "reset codes", row_code, {N{2'b10}});
      alt_phase = 1'b1;
      #1;
      check(row_code === {N{2'b01}}, "R1", "reset codes alt", row_code, {N{2'b01}});
      alt_phase = 1'b0;
      rst_n = 1'b1;

      // R2: walking marker through the full chain, downward
      step(0, 0, 0, 1, 0, 0, 1);
      for (int k = 1; k <= 20; k++) begin
         step(0, 0, 0, 0, 1, 0, 1);
         ones = 0; pos = -1;
         for (int i = 0; i < N; i++) if (row_code[2*i +: 2] == 2'b00) begin ones++; pos = i; end
         check(ones == 1 && pos == N - 1 - k, "R2", "marker position", pos, N - 1 - k);
      end

      // R4 then R6: fill upward, then split upward
      for (int k = 0; k < N; k++) step(0, 1, k[0], 0, 1, 0, 1);
      for (int k = 0; k < 90; k++) step(1, 1, 1, 0, k[1], 1, 1);

      // R5: split downward long enough to reach row 0
      for (int k = 0; k < 100; k++) step(1, 0, 0, k[2], 1, 0, 1);

      // R8: ones everywhere, then blank
      for (int k = 0; k < N; k++) step(0, 0, 0, 1, 0, 1, 1);
      step(0, 0, 0, 1, 0, 0, 0);
      all_base = {N{2'b11}};
      check(row_code === all_base, "R8", "blank over ones", row_code, all_base);

      // Mixed random traffic, selects changing at the shift edge
      for (int k = 0; k < 800; k++) begin
         step(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
              1'($urandom()), 1'($urandom()), ($urandom() % 5) != 0);
      end

      // R9: enables follow dir_up without a strobe edge
      @(posedge shift_strobe);
      #1 dir_up = 1'b1;
      #0.5;
      check({lo_oe, hi_oe} === 2'b01, "R9", "enables between edges", {lo_oe, hi_oe}, 2'b01);
      dir_up = 1'b0;
      #0.5;
      check({lo_oe, hi_oe} === 2'b10, "R9", "enables between edges", {lo_oe, hi_oe}, 2'b10);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule